// File: doc/BRIEF.md
# Two-Stage 1:16 Serial-to-Parallel Demultiplexer

The block turns a one-bit serial stream, sampled on every rising edge of the serial bit clock, into 16-bit parallel words at one sixteenth of the bit rate. The incoming bit is first retimed by a single flip-flop. A four-phase counter then steers successive bits to four lanes in turn, and each lane owns a 4-bit shift register. A second four-phase counter, advanced once per lane cycle, marks every sixteenth clock. On that edge a 16-bit output register takes all four lanes at once, so one complete word reaches the outputs.

The block also produces its own word clock and drives it out as a complementary pair. The positive leg is the inverted form of the usual receive-clock convention: the output word changes on the same edge where the positive leg falls. The block does no word alignment. The first bit presented after reset is released always becomes the most significant bit of the first word, so the word boundary is set by the moment reset is released.

Top module: `demux16_two_stage`

## Requirements
- R1: While reset is asserted, and until the first capture after release, `par_word` reads 0. `par_clk_p` reads 0 and `par_clk_n` reads 1.
- R2: Count as bit 0 the value of `ser_in` at the first rising edge after reset is released. Bits 0..15 then appear together on `par_word` right after the 18th rising edge following release: one edge for retiming, sixteen edges for the lane shifts, and one edge for capture.
- R3: Within each word, the bit received k-th (k = 0 for the earliest) is placed on `par_word[15-k]`. The first-received bit is therefore the MSB and the last-received bit is the LSB.
- R4: A new word is captured exactly every 16 clocks, and `par_word` holds its value on all edges in between.
- R5: Each output pin carries serial bits spaced 16 apart in successive words. `par_word[15]` carries bits 0, 16, 32, …, and `par_word[0]` carries bits 15, 31, 47, ….
- R6: `par_word` changes only on an edge where `par_clk_p` falls.
- R7: `par_clk_p` has a period of 16 clocks and stays high for 8 of them. It first rises on the 10th edge after release, which is mid-word, and falls on each capture edge.
- R8: `par_clk_n` is always the complement of `par_clk_p`.
- R9: If reset is asserted again in the middle of a stream, the word boundary restarts. The first bit after the new release becomes the MSB of the next word delivered.

Each requirement above is checked in the default configuration: 4 lanes of 4 bits, MSB-first, with the inverted word clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ser | input | 1 | Serial bit clock; every register in the block is clocked on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data input, one bit per clock |
| par_word | output | 16 | Assembled parallel word, first-received bit in the MSB |
| par_clk_p | output | 1 | Exported word clock, positive leg; falls on the edge where the word updates |
| par_clk_n | output | 1 | Exported word clock, negative leg |

## Verification
On the capture edge, three things happen in the same cycle. The output register takes the completed word, lane 0 shifts in the first bit of the next word, and the exported clock falls. A mistake here either moves a bit from one word into its neighbour or moves the clock edge away from the data edge. Continuous streams keep every capture edge paired with a live lane-0 shift. These streams include a pseudo-random sequence, a sparse single-one pattern whose ones walk through every lane and slot, and two periodic patterns. Each captured word is compared with the word rebuilt in the bench from the MSB-first rule. Clock level and data stability are checked on every edge. Runs end part-way through a word before reset is asserted again, which tests whether the boundary restarts.

// File: rtl/demux16_pkg.sv
package demux16_pkg;

   // Output bit position of lane register bit `r` in lane `lane`.
   // The lane register's top bit holds the earliest bit of that lane.
   function automatic int out_pos(input int lane, input int r,
                                  input int lanes, input int depth,
                                  input bit msb_first);
      int slot;
      int order;
      slot  = depth - 1 - r;
      order = slot * lanes + lane;
      return msb_first ? (lanes * depth - 1 - order) : order;
   endfunction

endpackage

// File: rtl/demux16_divider.sv
module demux16_divider #(
   parameter int LANES   = 4,
   parameter int DEPTH   = 4
) (
   input  logic             clk,
   input  logic             rst,
   output logic [LANES-1:0] lane_en,
   output logic             cap_en,
   output logic             wclk
);
   localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int GW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int WORD_W = LANES * DEPTH;
   localparam int HW     = $clog2(WORD_W) + 1;

   initial begin
      assert (LANES >= 2) else $error("demux16_divider: LANES must be at least 2");
      assert (DEPTH >= 2 && DEPTH % 2 == 0)
         else $error("demux16_divider: DEPTH must be even and at least 2");
   end

   logic [LW-1:0] ph;
   logic [GW-1:0] grp;
   logic          ph_last;
   logic          grp_last;

   assign ph_last  = (ph  == LW'(LANES - 1));
   assign grp_last = (grp == GW'(DEPTH - 1));

   // First stage: lane phase; second stage: lane-cycle group.
   // Both start on their terminal phase so the first live edge is phase 0.
   always_ff @(posedge clk) begin
      if (rst) begin
         ph  <= LW'(LANES - 1);
         grp <= GW'(DEPTH - 1);
      end else begin
         ph <= ph_last ? '0 : ph + 1'b1;
         if (ph_last)
            grp <= grp_last ? '0 : grp + 1'b1;
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane_en
      assign lane_en[k] = (ph == LW'(k));
   end

   assign cap_en = (ph == '0) && (grp == '0);

   always_ff @(posedge clk) begin
      if (rst)
         wclk <= 1'b0;
      else if (cap_en)
         wclk <= 1'b0;
      else if (ph == '0 && grp == GW'(DEPTH / 2))
         wclk <= 1'b1;
   end

   // Checker: width of the high phase of the word clock
   logic [HW-1:0] hi_len;
   always_ff @(posedge clk) begin
      if (rst)
         hi_len <= '0;
      else if (wclk)
         hi_len <= hi_len + 1'b1;
      else
         hi_len <= '0;
   end

   a_r7_high_half: assert property (@(posedge clk) disable iff (rst)
      $fell(wclk) |-> hi_len == HW'(WORD_W / 2));

   a_r4_capture_follows_last_lane: assert property (@(posedge clk) disable iff (rst)
      cap_en |-> $past(lane_en[LANES-1]));

endmodule

// File: rtl/demux16_lane.sv
module demux16_lane #(
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             din,
   output logic [DEPTH-1:0] q
);
   initial begin
      assert (DEPTH >= 2) else $error("demux16_lane: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (en)
         q <= {q[DEPTH-2:0], din};
   end

endmodule

// File: rtl/demux16_capture.sv
module demux16_capture #(
   parameter int LANES     = 4,
   parameter int DEPTH     = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   cap_en,
   input  logic [LANES*DEPTH-1:0] lanes,
   output logic [LANES*DEPTH-1:0] word
);
   localparam int WORD_W = LANES * DEPTH;

   logic [WORD_W-1:0] mapped;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      for (genvar r = 0; r < DEPTH; r++) begin : g_bit
         localparam int POS = demux16_pkg::out_pos(k, r, LANES, DEPTH, MSB_FIRST);
         assign mapped[POS] = lanes[k*DEPTH + r];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         word <= '0;
      else if (cap_en)
         word <= mapped;
   end

endmodule

// File: rtl/demux16_two_stage.sv
module demux16_two_stage #(
   parameter int LANES     = 4,
   parameter int DEPTH     = 4,
   parameter bit MSB_FIRST = 1'b1,
   parameter bit WCLK_INV  = 1'b1,
   localparam int WORD_W   = LANES * DEPTH
) (
   input  logic              clk_ser,
   input  logic              rst,
   input  logic              ser_in,
   output logic [WORD_W-1:0] par_word,
   output logic              par_clk_p,
   output logic              par_clk_n
);
   initial begin
      assert (WORD_W <= 1024) else $error("demux16_two_stage: word too wide");
   end

   logic              sd_q;
   logic [LANES-1:0]  lane_en;
   logic              cap_en;
   logic              wclk;
   logic [WORD_W-1:0] lane_bits;

   always_ff @(posedge clk_ser) begin
      if (rst)
         sd_q <= 1'b0;
      else
         sd_q <= ser_in;
   end

   demux16_divider #(.LANES(LANES), .DEPTH(DEPTH)) u_div (
      .clk     (clk_ser),
      .rst     (rst),
      .lane_en (lane_en),
      .cap_en  (cap_en),
      .wclk    (wclk)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      demux16_lane #(.DEPTH(DEPTH)) u_lane (
         .clk (clk_ser),
         .rst (rst),
         .en  (lane_en[k]),
         .din (sd_q),
         .q   (lane_bits[k*DEPTH +: DEPTH])
      );
   end

   demux16_capture #(.LANES(LANES), .DEPTH(DEPTH), .MSB_FIRST(MSB_FIRST)) u_cap (
      .clk    (clk_ser),
      .rst    (rst),
      .cap_en (cap_en),
      .lanes  (lane_bits),
      .word   (par_word)
   );

   if (WCLK_INV) begin : g_wclk_inv
      assign par_clk_p = wclk;
      assign par_clk_n = ~wclk;

      a_r6_word_on_fall: assert property (@(posedge clk_ser) disable iff (rst)
         (par_word != $past(par_word)) |-> $fell(par_clk_p));
   end else begin : g_wclk_std
      assign par_clk_p = ~wclk;
      assign par_clk_n = wclk;
   end

   a_r4_single_lane: assert property (@(posedge clk_ser) disable iff (rst)
      $onehot0(lane_en));

endmodule

// File: tb/demux16_two_stage_bench.sv
`timescale 1ns/1ps
module demux16_two_stage_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        ser_in;
   logic [15:0] par_word;
   logic        par_clk_p;
   logic        par_clk_n;

   int checks = 0;
   int errors = 0;

   logic prbs [0:1023];

   always #2.5 clk = ~clk;

   demux16_two_stage u_demux16_two_stage (
      .clk_ser   (clk),
      .rst       (rst),
      .ser_in    (ser_in),
      .par_word  (par_word),
      .par_clk_p (par_clk_p),
      .par_clk_n (par_clk_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic pat_bit(input int p, input int j);
      case (p)
         0:       return prbs[j];
         1:       return (j % 17) == 0;
         2:       return j[0];
         3:       return ((j / 3) % 2) == 1;
         default: return prbs[(j + 300) % 1024];
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      ser_in = 1'b1;
      repeat (2) @(negedge clk);
      // R1: reset state
      chk(par_word === 16'h0, "R1", "word in reset", par_word, 16'h0);
      chk(par_clk_p === 1'b0, "R1", "clk_p in reset", {15'b0, par_clk_p}, 16'h0);
      chk(par_clk_n === 1'b1, "R1", "clk_n in reset", {15'b0, par_clk_n}, 16'h1);
   endtask

   task automatic run(input int p, input int nbits, input bit after_restart);
      logic [15:0] last_exp;
      logic [15:0] prev_word;
      logic        prev_clk;
      logic [15:0] exp;
      logic        exp_clk;
      int          w;
      last_exp  = 16'h0;
      prev_word = 16'h0;
      prev_clk  = 1'b0;
      // at this negedge reset is released and bit 0 is presented
      rst    = 1'b0;
      ser_in = pat_bit(p, 0);
      for (int t = 1; t <= nbits; t++) begin
         @(negedge clk);
         // outputs now reflect edge number t after release
         chk(par_clk_n === ~par_clk_p, "R8", "clk_n complement",
             {15'b0, par_clk_n}, {15'b0, ~par_clk_p});
         exp_clk = (t >= 10) && (((t - 10) % 16) < 8);
         chk(par_clk_p === exp_clk, "R7", "word clock level",
             {15'b0, par_clk_p}, {15'b0, exp_clk});
         if (t >= 18 && ((t - 18) % 16) == 0) begin
            w = (t - 18) / 16;
            for (int k = 0; k < 16; k++)
               exp[15-k] = pat_bit(p, 16 * w + k);
            if (w == 0 && after_restart)
               chk(par_word === exp, "R9", "first word after restart", par_word, exp);
            else if (w == 0)
               chk(par_word === exp, "R2", "first word latency", par_word, exp);
            else
               chk(par_word === exp, "R3", "MSB-first word", par_word, exp);
            chk(par_word[15] === pat_bit(p, 16 * w), "R5", "MSB pin bit spacing",
                {15'b0, par_word[15]}, {15'b0, pat_bit(p, 16 * w)});
            chk(par_word[0] === pat_bit(p, 16 * w + 15), "R5", "LSB pin bit spacing",
                {15'b0, par_word[0]}, {15'b0, pat_bit(p, 16 * w + 15)});
            last_exp = exp;
         end else begin
            chk(par_word === last_exp, "R4", "word held between captures",
                par_word, last_exp);
         end
         if (par_word !== prev_word)
            chk(prev_clk === 1'b1 && par_clk_p === 1'b0, "R6", "update on clk_p fall",
                {14'b0, prev_clk, par_clk_p}, 16'h2);
         prev_word = par_word;
         prev_clk  = par_clk_p;
         ser_in    = pat_bit(p, t);
      end
   endtask

   initial begin
      logic [6:0] s;
      logic       nb;
      s = 7'h7F;
      for (int j = 0; j < 1024; j++) begin
         nb = s[6] ^ s[5];
         s  = {s[5:0], nb};
         prbs[j] = nb;
      end
      rst    = 1'b1;
      ser_in = 1'b0;
      do_reset();
      run(0, 16 * 20 + 7, 1'b0);   // pseudo-random, ends mid-word
      do_reset();
      run(1, 16 * 12 + 3, 1'b1);   // sparse single ones walking all lanes
      do_reset();
      run(2, 16 * 8 + 11, 1'b1);   // alternating
      do_reset();
      run(3, 16 * 8, 1'b1);        // period-six pattern
      do_reset();
      run(4, 16 * 10 + 5, 1'b1);   // pseudo-random, different offset
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule